// File: doc/BRIEF.md
# Presence-Detect Hot Plug Event Logic

This block tracks device insertion and removal for a single PCIe root port whose only hot plug mechanism is presence detection. A raw presence indication from the physical layer passes through a two-flop synchronizer. It must then hold its new level for a programmable number of cycles before the reported presence state follows it.

Every accepted change of the presence state sets a sticky change flag. Software clears that flag by writing a one. Software also owns two enable bits: a change-event enable and a hot-plug interrupt enable. When the change flag goes from 0 to 1 while both enables are set, the block emits a one-cycle interrupt request. Downstream logic can route that request as a legacy wire interrupt, a message interrupt or a system event.

Top module: `hp_presence_detect`

## Requirements
- R1: When the synchronized presence input rises and stays high, `pres_state` becomes 1 and `pres_chg` becomes 1. Counting from the first clock edge that samples the new raw level, this happens at edge number 3 + `stable_cycles`, and not earlier.
- R2: When the synchronized presence input falls and stays low, `pres_state` becomes 0 and `pres_chg` becomes 1, with the same timing as R1.
- R3: A raw level that differs from `pres_state` for fewer than `stable_cycles` + 1 consecutive synchronized samples changes neither `pres_state` nor `pres_chg`.
- R4: `pres_chg` is sticky. It stays set until a cycle with `chg_clr` high, and it reads 0 after that edge when no presence change is accepted on the same edge.
- R5: If `chg_clr` is high on the same edge where a presence change is accepted, `pres_chg` stays 1.
- R6: `hp_irq` is high for exactly one cycle, on the edge where `pres_chg` goes from 0 to 1, when `chg_en` and `int_en` were both 1 before that edge.
- R7: If either `chg_en` or `int_en` is 0, a 0-to-1 transition of `pres_chg` produces no `hp_irq`.
- R8: Setting both enables while `pres_chg` is already 1 produces no `hp_irq`.
- R9: Reset clears `pres_chg`, `chg_en`, `int_en` and `hp_irq`. It loads `pres_state` from the synchronized input without setting `pres_chg`.
- R10: A cycle with `en_we` high loads `en_wdata[0]` into `chg_en` and `en_wdata[1]` into `int_en`. Both bits are visible on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| present_raw | input | 1 | Unsynchronized presence indication from the physical layer |
| stable_cycles | input | CNT_W | Extra cycles a new level must hold before it is accepted |
| chg_clr | input | 1 | Software wrote 1 to the change flag |
| en_we | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 2 | Bit 0 is the change-event enable, bit 1 is the interrupt enable |
| pres_state | output | 1 | Accepted presence state |
| pres_chg | output | 1 | Sticky presence-changed flag |
| chg_en | output | 1 | Change-event enable readback |
| int_en | output | 1 | Hot-plug interrupt enable readback |
| hp_irq | output | 1 | One-cycle interrupt request |

## Verification
The bench drives several presence patterns and checks what each one distinguishes:
- A clean insertion and a clean removal with a debounce count of 3 show that the latency is exact and not early by one edge.
- The same events with a count of 0 check the shortest path through the logic.
- A two-cycle glitch, shorter than the debounce window, must leave both the state and the flag untouched.
- The enables are tried all set, each one alone, and set late while the flag is already 1. These cases separate a true rising-edge interrupt from one that follows the level of the flag.
- A clear that lands on the same edge as a new change checks that setting the flag wins over clearing it.
- Reset is applied once with the device absent and once with it present.

// File: rtl/hp_presence_detect.sv
module hp_presence_detect #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             present_raw,
  input  logic [CNT_W-1:0] stable_cycles,
  input  logic             chg_clr,
  input  logic             en_we,
  input  logic [1:0]       en_wdata,
  output logic             pres_state,
  output logic             pres_chg,
  output logic             chg_en,
  output logic             int_en,
  output logic             hp_irq
);

  logic             sync_a, sync_b;
  logic [CNT_W-1:0] hold_cnt;
  logic             differs, accept, chg_next;

  always_ff @(posedge clk) begin
    sync_a <= present_raw;
    sync_b <= sync_a;
  end

  assign differs  = sync_b != pres_state;
  assign accept   = differs && (hold_cnt >= stable_cycles);
  assign chg_next = accept || (pres_chg && !chg_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_state <= sync_b;
      hold_cnt   <= '0;
    end else if (!differs || accept) begin
      pres_state <= accept ? sync_b : pres_state;
      hold_cnt   <= '0;
    end else begin
      hold_cnt   <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_chg <= 1'b0;
      chg_en   <= 1'b0;
      int_en   <= 1'b0;
      hp_irq   <= 1'b0;
    end else begin
      pres_chg <= chg_next;
      hp_irq   <= chg_next && !pres_chg && chg_en && int_en;
      if (en_we) begin
        chg_en <= en_wdata[0];
        int_en <= en_wdata[1];
      end
    end
  end

endmodule

module hp_presence_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic pres_state,
  input logic pres_chg,
  input logic chg_clr,
  input logic chg_en,
  input logic int_en,
  input logic hp_irq
);

  assert_state_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_state != $past(pres_state)) |-> pres_chg);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pres_chg) && !$past(chg_clr)) |-> pres_chg);

  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chg_clr) && $stable(pres_state)) |-> !pres_chg);

  assert_irq_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |-> (pres_chg && !$past(pres_chg)));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |=> !hp_irq);

  assert_irq_needs_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |-> ($past(chg_en) && $past(int_en)));

endmodule

bind hp_presence_detect hp_presence_detect_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pres_state(pres_state), .pres_chg(pres_chg),
  .chg_clr(chg_clr), .chg_en(chg_en), .int_en(int_en), .hp_irq(hp_irq)
);

// File: tb/hp_presence_detect_tb_top.sv
module hp_presence_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, present_raw, chg_clr, en_we;
  logic [7:0] stable_cycles;
  logic [1:0] en_wdata;
  logic       pres_state, pres_chg, chg_en, int_en, hp_irq;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  hp_presence_detect #(.CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .present_raw(present_raw),
    .stable_cycles(stable_cycles), .chg_clr(chg_clr), .en_we(en_we),
    .en_wdata(en_wdata), .pres_state(pres_state), .pres_chg(pres_chg),
    .chg_en(chg_en), .int_en(int_en), .hp_irq(hp_irq)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_en(logic [1:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic clear_flag();
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset_absent();
    present_raw = 1'b0;
    do_reset();
    check("R9", "pres_state", pres_state, 1'b0);
    check("R9", "pres_chg", pres_chg, 1'b0);
    check("R9", "enables", chg_en | int_en, 1'b0);
    check("R9", "hp_irq", hp_irq, 1'b0);
  endtask

  task automatic t_enable_write();
    write_en(2'b11);
    check("R10", "chg_en", chg_en, 1'b1);
    check("R10", "int_en", int_en, 1'b1);
    write_en(2'b01);
    check("R10", "chg_en", chg_en, 1'b1);
    check("R10", "int_en", int_en, 1'b0);
  endtask

  task automatic t_insert_irq();
    int n = int'(stable_cycles);
    write_en(2'b11);
    present_raw = 1'b1;
    wait_n(2 + n);
    check("R1", "pres_state early", pres_state, 1'b0);
    check("R1", "pres_chg early", pres_chg, 1'b0);
    wait_n(1);
    check("R1", "pres_state", pres_state, 1'b1);
    check("R1", "pres_chg", pres_chg, 1'b1);
    check("R6", "hp_irq pulse", hp_irq, 1'b1);
    wait_n(1);
    check("R6", "hp_irq one cycle", hp_irq, 1'b0);
  endtask

  task automatic t_sticky_clear();
    wait_n(6);
    check("R4", "flag held", pres_chg, 1'b1);
    clear_flag();
    check("R4", "flag cleared", pres_chg, 1'b0);
  endtask

  task automatic t_glitch();
    present_raw = 1'b0;
    wait_n(2);
    present_raw = 1'b1;
    wait_n(10);
    check("R3", "pres_state after glitch", pres_state, 1'b1);
    check("R3", "pres_chg after glitch", pres_chg, 1'b0);
  endtask

  task automatic t_remove_one_enable();
    int n = int'(stable_cycles);
    write_en(2'b01);
    present_raw = 1'b0;
    wait_n(3 + n);
    check("R2", "pres_state", pres_state, 1'b0);
    check("R2", "pres_chg", pres_chg, 1'b1);
    check("R7", "hp_irq chg_en only", hp_irq, 1'b0);
    wait_n(1);
    check("R7", "hp_irq next cycle", hp_irq, 1'b0);
  endtask

  task automatic t_late_enable();
    write_en(2'b11);
    for (int i = 0; i < 4; i++) begin
      check("R8", "hp_irq after late enable", hp_irq, 1'b0);
      wait_n(1);
    end
  endtask

  task automatic t_clear_collide();
    int n = int'(stable_cycles);
    present_raw = 1'b1;
    wait_n(2 + n);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    check("R5", "pres_state", pres_state, 1'b1);
    check("R5", "pres_chg kept", pres_chg, 1'b1);
    check("R8", "no irq without 0-to-1", hp_irq, 1'b0);
  endtask

  task automatic t_zero_window();
    stable_cycles = 8'd0;
    clear_flag();
    present_raw = 1'b0;
    wait_n(2);
    check("R2", "pres_state early n=0", pres_state, 1'b1);
    wait_n(1);
    check("R2", "pres_state n=0", pres_state, 1'b0);
    check("R6", "hp_irq n=0", hp_irq, 1'b1);
    write_en(2'b10);
    clear_flag();
    present_raw = 1'b1;
    wait_n(3);
    check("R1", "pres_state n=0", pres_state, 1'b1);
    check("R1", "pres_chg n=0", pres_chg, 1'b1);
    check("R7", "hp_irq int_en only", hp_irq, 1'b0);
  endtask

  task automatic t_reset_present();
    do_reset();
    check("R9", "pres_state loaded", pres_state, 1'b1);
    check("R9", "pres_chg after reset", pres_chg, 1'b0);
    check("R9", "enables after reset", chg_en | int_en, 1'b0);
    check("R9", "hp_irq after reset", hp_irq, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; present_raw = 1'b0; chg_clr = 1'b0;
    en_we = 1'b0; en_wdata = 2'b00; stable_cycles = 8'd3;
    @(negedge clk);
    t_reset_absent();
    t_enable_write();
    t_insert_irq();
    t_sticky_clear();
    t_glitch();
    t_remove_one_enable();
    t_late_enable();
    t_clear_collide();
    t_zero_window();
    t_reset_present();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule